// File: doc/BRIEF.md
# Gigabit PCS Link Control and Resolution

This block holds the software-visible link control word of a gigabit physical coding sublayer and turns it, together with the results of an external autonegotiation and code-group sync engine, into the link state, speed and duplex that the MAC sees. Software writes the control word through a single-cycle write strobe and can read it back at any time. The resolved link, speed and duplex are combinational functions of the stored control word and the engine inputs, so they follow a change of either without added delay.

The block also drives the control lines of the autonegotiation engine. These are an enable level, a one-cycle restart pulse, a start trigger and an idle-detect bypass. It gates sync-failure triggering in SGMII mode and applies a link-up-on-idle timeout only in SerDes mode. A separate link status output can be set to hold a drop of the link low until the processor acknowledges it with a read strobe. The engine, the sync logic and the SerDes are outside the block and appear only as ports.

Top module: `pcs_link_ctrl`

## Requirements
- R1: After reset the control word reads back 0x0004000C: forced speed code 10, forced duplex full, timeout enable set, every other bit clear.
- R2: Only bits 0-6 and 16-20 are writable. All other bits read as zero, and a write of all ones reads back 0x001F007F in the first cycle and 0x001D007F after it.
- R3: When force-link (bit 5) is set, link_up equals bit 0 (1 = up). Otherwise it is 1 when the engine reports link OK or when the timeout of R4 applies.
- R4: The idle timeout raises link_up only when timeout enable (bit 18) and autonegotiation enable (bit 16) are both set, the port is in SerDes mode (sgmii_mode = 0) and idle_timeout is 1.
- R5: speed and full_duplex take the forced values from bits 2:1 and bit 3 when any of these holds: force-speed-duplex (bit 4) is set, autonegotiation is disabled, or the port is in SerDes mode. Otherwise they take the negotiated inputs. Speed codes are 00 = 10 Mb/s, 01 = 100 Mb/s and 10 = 1000 Mb/s; duplex 1 means full.
- R6: The reserved speed code 11 from either source is reported as 10 (1000 Mb/s), and speed never shows 11.
- R7: With latch-low enable (bit 6) set, a falling edge of link_up drives link_stat low until a cycle in which stat_rd is 1. After that cycle link_stat follows link_up again. With bit 6 clear, link_stat always equals link_up.
- R8: Writing 1 to bit 17 makes an_restart 1 for exactly the cycle after the write, and bit 17 reads back 1 only in that cycle.
- R9: an_trigger is 0 while autonegotiation is disabled. Otherwise it is 1 in the cycle after a write with bit 16 set, while an_restart is 1, while phy_msg is 1, or on sync_fail. In SGMII mode, sync_fail counts only when trigger enable (bit 20) is set.
- R10: an_idle_bypass is 1 exactly when bit 19 and bit 16 are set and the port is in SGMII mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 32 | Control word write value |
| rd_data | output | 32 | Control word read value |
| stat_rd | input | 1 | Processor read of link status; releases a held-low status |
| sgmii_mode | input | 1 | 1 = SGMII, 0 = SerDes |
| an_link_ok | input | 1 | Link OK from the autonegotiation/sync engine |
| an_speed | input | 2 | Negotiated speed code |
| an_duplex | input | 1 | Negotiated duplex, 1 = full |
| sync_fail | input | 1 | Code-group sync lost |
| idle_timeout | input | 1 | Partner sent idles but no negotiation pages |
| phy_msg | input | 1 | PHY message requesting negotiation |
| link_up | output | 1 | Effective link state |
| speed | output | 2 | Effective speed code |
| full_duplex | output | 1 | Effective duplex |
| link_stat | output | 1 | Link status with optional latch-low |
| an_enable | output | 1 | Autonegotiation enable level |
| an_restart | output | 1 | One-cycle autonegotiation restart pulse |
| an_trigger | output | 1 | Autonegotiation start request |
| an_idle_bypass | output | 1 | Skip idle detect during negotiation |

## Verification
The link, speed and duplex outputs are combinational, so they are sampled one time step after the inputs change, or at the first falling clock edge after the write edge that stores a new control word. The restart pulse, the bit 17 readback and the write-enable part of the trigger are due at exactly that same falling edge and are gone at the next one, and the bench checks both edges. A held-low status appears at the falling edge after the clock edge that saw the link drop. It is released at the falling edge after the clock edge that saw stat_rd, and the bench samples only at those edges.

// File: rtl/pcs_lctl_pkg.sv
// Package: shared field positions, the decoded control word type, the
// speed code type and pack/unpack helpers for the PCS link control block.
// Assumes a 32-bit control word; unlisted bits are unimplemented.
package pcs_lctl_pkg;

    localparam int REG_W   = 32;
    localparam int SPD_W   = 2;

    localparam int B_FLINK = 0;
    localparam int B_FSPD  = 1;
    localparam int B_FDUP  = 3;
    localparam int B_FSD   = 4;
    localparam int B_FRC   = 5;
    localparam int B_LLE   = 6;
    localparam int B_ANEN  = 16;
    localparam int B_ANRS  = 17;
    localparam int B_TMO   = 18;
    localparam int B_BYP   = 19;
    localparam int B_TRG   = 20;

    typedef enum logic [SPD_W-1:0] {
        SPD_10   = 2'b00,
        SPD_100  = 2'b01,
        SPD_1000 = 2'b10,
        SPD_RSVD = 2'b11
    } speed_e;

    typedef struct packed {
        logic   trig_en;
        logic   idle_byp;
        logic   tmo_en;
        logic   an_en;
        logic   latch_en;
        logic   force_link;
        logic   force_sd;
        logic   frc_full;
        speed_e frc_speed;
        logic   frc_link;
    } lctl_t;

    localparam lctl_t CTRL_RST = '{
        trig_en:    1'b0,
        idle_byp:   1'b0,
        tmo_en:     1'b1,
        an_en:      1'b0,
        latch_en:   1'b0,
        force_link: 1'b0,
        force_sd:   1'b0,
        frc_full:   1'b1,
        frc_speed:  SPD_1000,
        frc_link:   1'b0
    };

    // Decode a written word into the stored control fields.
    function automatic lctl_t unpack_ctrl(input logic [REG_W-1:0] w);
        lctl_t c;
        c.frc_link   = w[B_FLINK];
        c.frc_speed  = speed_e'(w[B_FSPD +: SPD_W]);
        c.frc_full   = w[B_FDUP];
        c.force_sd   = w[B_FSD];
        c.force_link = w[B_FRC];
        c.latch_en   = w[B_LLE];
        c.an_en      = w[B_ANEN];
        c.tmo_en     = w[B_TMO];
        c.idle_byp   = w[B_BYP];
        c.trig_en    = w[B_TRG];
        return c;
    endfunction

    // Encode the stored fields and the restart flag into a read value.
    function automatic logic [REG_W-1:0] pack_ctrl(input lctl_t c, input logic rs);
        logic [REG_W-1:0] w;
        w = '0;
        w[B_FLINK]         = c.frc_link;
        w[B_FSPD +: SPD_W] = c.frc_speed;
        w[B_FDUP]          = c.frc_full;
        w[B_FSD]           = c.force_sd;
        w[B_FRC]           = c.force_link;
        w[B_LLE]           = c.latch_en;
        w[B_ANEN]          = c.an_en;
        w[B_ANRS]          = rs;
        w[B_TMO]           = c.tmo_en;
        w[B_BYP]           = c.idle_byp;
        w[B_TRG]           = c.trig_en;
        return w;
    endfunction

    // Map a speed code to a legal one; the reserved code becomes gigabit.
    function automatic speed_e legal_speed(input speed_e s);
        return (s == SPD_RSVD) ? SPD_1000 : s;
    endfunction

endpackage

// File: rtl/pcs_lctl_regs.sv
// Control word storage. Holds the writable fields, produces the one-cycle
// restart flag and a one-cycle "enable written" flag, and forms the
// read value. Assumes wr_en is a single-cycle strobe in the clk domain.
module pcs_lctl_regs
    import pcs_lctl_pkg::*;
#(
    parameter int W = REG_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] rd_data,
    output lctl_t        ctrl,
    output logic         restart,
    output logic         en_written
);

    localparam logic [W-1:0] KEEP_MASK =
        W'((1 << B_FLINK) | (3 << B_FSPD) | (1 << B_FDUP) | (1 << B_FSD) |
           (1 << B_FRC) | (1 << B_LLE) | (1 << B_ANEN) | (1 << B_TMO) |
           (1 << B_BYP) | (1 << B_TRG));

    lctl_t ctrl_q;
    logic  restart_q;
    logic  en_wr_q;

    // Store the writable fields on a write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= CTRL_RST;
        else if (wr_en)
            ctrl_q <= unpack_ctrl(wr_data);
    end

    // Self-clearing restart flag and enable-written flag, one cycle each.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            restart_q <= 1'b0;
            en_wr_q   <= 1'b0;
        end else begin
            restart_q <= wr_en & wr_data[B_ANRS];
            en_wr_q   <= wr_en & wr_data[B_ANEN];
        end
    end

    // Read value and field outputs.
    always_comb begin
        rd_data    = pack_ctrl(ctrl_q, restart_q);
        ctrl       = ctrl_q;
        restart    = restart_q;
        en_written = en_wr_q;
    end

    AST_RESTART_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        restart_q |=> !restart_q); // R8
    AST_WRITE_KEEPS_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ((rd_data & KEEP_MASK) == ($past(wr_data) & KEEP_MASK))); // R2

endmodule

// File: rtl/pcs_lctl_resolve.sv
// Link, speed and duplex resolution. Purely combinational: picks forced
// or negotiated values from the control fields, the port mode and the
// engine results. Assumes the engine inputs are already in the clk domain.
module pcs_lctl_resolve
    import pcs_lctl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  lctl_t      ctrl,
    input  logic       sgmii_mode,
    input  logic       an_link_ok,
    input  speed_e     an_speed,
    input  logic       an_duplex,
    input  logic       idle_timeout,
    output logic       link_up,
    output speed_e     speed,
    output logic       full_duplex
);

    logic tmo_up;
    logic use_forced;

    // Link: forced value or engine result, with SerDes idle timeout.
    always_comb begin
        tmo_up = ctrl.tmo_en & ctrl.an_en & ~sgmii_mode & idle_timeout;
        if (ctrl.force_link)
            link_up = ctrl.frc_link;
        else
            link_up = an_link_ok | tmo_up;
    end

    // Speed and duplex: forced when requested, negotiation off, or SerDes.
    always_comb begin
        use_forced = ctrl.force_sd | ~ctrl.an_en | ~sgmii_mode;
        if (use_forced) begin
            speed       = legal_speed(ctrl.frc_speed);
            full_duplex = ctrl.frc_full;
        end else begin
            speed       = legal_speed(an_speed);
            full_duplex = an_duplex;
        end
    end

    AST_SPEED_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        speed != SPD_RSVD); // R6

endmodule

// File: rtl/pcs_lctl_latch.sv
// Latch-low link status. When enabled, a falling edge of the link is held
// low until the processor read strobe; otherwise the status is live.
// Assumes stat_rd is a single-cycle strobe; a fall in the same cycle wins.
module pcs_lctl_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic latch_en,
    input  logic link,
    input  logic stat_rd,
    output logic link_stat
);

    logic prev_q;
    logic held_q;
    logic fall;

    // Detect a falling edge against last cycle's link.
    always_comb fall = prev_q & ~link;

    // Remember last cycle's link state.
    always_ff @(posedge clk) begin
        if (!rst_n)
            prev_q <= 1'b0;
        else
            prev_q <= link;
    end

    // Hold flag: set on a fall, released by a read or by disabling.
    always_ff @(posedge clk) begin
        if (!rst_n)
            held_q <= 1'b0;
        else if (!latch_en)
            held_q <= 1'b0;
        else if (fall)
            held_q <= 1'b1;
        else if (stat_rd)
            held_q <= 1'b0;
    end

    // Reported status: low while held, live otherwise.
    always_comb link_stat = ~held_q & link;

    AST_FALL_HELD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_en && prev_q && !link) |=> !link_stat); // R7

endmodule

// File: rtl/pcs_lctl_antrig.sv
// Autonegotiation control lines: enable level, restart pulse, start
// trigger with SGMII sync-fail gating, and SGMII idle-detect bypass.
// Assumes restart and en_written are one-cycle flags from the registers.
module pcs_lctl_antrig
    import pcs_lctl_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  lctl_t ctrl,
    input  logic  restart,
    input  logic  en_written,
    input  logic  sgmii_mode,
    input  logic  sync_fail,
    input  logic  phy_msg,
    output logic  an_enable,
    output logic  an_restart,
    output logic  an_trigger,
    output logic  an_idle_bypass
);

    logic sync_req;

    // Sync failure starts negotiation unless gated off in SGMII mode.
    always_comb sync_req = sync_fail & (~sgmii_mode | ctrl.trig_en);

    // Drive the engine control lines.
    always_comb begin
        an_enable      = ctrl.an_en;
        an_restart     = restart;
        an_trigger     = ctrl.an_en & (restart | en_written | phy_msg | sync_req);
        an_idle_bypass = ctrl.an_en & ctrl.idle_byp & sgmii_mode;
    end

    AST_NO_TRIG_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        !an_enable |-> !an_trigger); // R9

endmodule

// File: rtl/pcs_link_ctrl.sv
// Top: PCS link control word with link, speed and duplex resolution,
// latch-low status and autonegotiation control lines. Assumes a single
// clock domain and synchronous active-low reset.
module pcs_link_ctrl
    import pcs_lctl_pkg::*;
#(
    parameter int DATA_W = REG_W,
    parameter int SPEED_W = SPD_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [DATA_W-1:0]  wr_data,
    output logic [DATA_W-1:0]  rd_data,
    input  logic               stat_rd,
    input  logic               sgmii_mode,
    input  logic               an_link_ok,
    input  logic [SPEED_W-1:0] an_speed,
    input  logic               an_duplex,
    input  logic               sync_fail,
    input  logic               idle_timeout,
    input  logic               phy_msg,
    output logic               link_up,
    output logic [SPEED_W-1:0] speed,
    output logic               full_duplex,
    output logic               link_stat,
    output logic               an_enable,
    output logic               an_restart,
    output logic               an_trigger,
    output logic               an_idle_bypass
);

    lctl_t  ctrl;
    logic   restart;
    logic   en_written;
    speed_e spd_res;

    pcs_lctl_regs #(.W(DATA_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .rd_data    (rd_data),
        .ctrl       (ctrl),
        .restart    (restart),
        .en_written (en_written)
    );

    pcs_lctl_resolve u_resolve (
        .clk          (clk),
        .rst_n        (rst_n),
        .ctrl         (ctrl),
        .sgmii_mode   (sgmii_mode),
        .an_link_ok   (an_link_ok),
        .an_speed     (speed_e'(an_speed)),
        .an_duplex    (an_duplex),
        .idle_timeout (idle_timeout),
        .link_up      (link_up),
        .speed        (spd_res),
        .full_duplex  (full_duplex)
    );

    // Present the resolved speed code at the port width.
    always_comb speed = SPEED_W'(spd_res);

    pcs_lctl_latch u_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .latch_en  (ctrl.latch_en),
        .link      (link_up),
        .stat_rd   (stat_rd),
        .link_stat (link_stat)
    );

    pcs_lctl_antrig u_antrig (
        .clk            (clk),
        .rst_n          (rst_n),
        .ctrl           (ctrl),
        .restart        (restart),
        .en_written     (en_written),
        .sgmii_mode     (sgmii_mode),
        .sync_fail      (sync_fail),
        .phy_msg        (phy_msg),
        .an_enable      (an_enable),
        .an_restart     (an_restart),
        .an_trigger     (an_trigger),
        .an_idle_bypass (an_idle_bypass)
    );

    AST_FORCED_LINK_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.force_link && !ctrl.frc_link) |-> !link_stat); // R3

endmodule

// File: tb/sim_pcs_link_ctrl.sv
module sim_pcs_link_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        stat_rd = 1'b0;
    logic        sgmii_mode = 1'b1;
    logic        an_link_ok = 1'b0;
    logic [1:0]  an_speed = 2'b00;
    logic        an_duplex = 1'b0;
    logic        sync_fail = 1'b0;
    logic        idle_timeout = 1'b0;
    logic        phy_msg = 1'b0;
    logic        link_up, full_duplex, link_stat;
    logic [1:0]  speed;
    logic        an_enable, an_restart, an_trigger, an_idle_bypass;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pcs_link_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .stat_rd(stat_rd), .sgmii_mode(sgmii_mode),
        .an_link_ok(an_link_ok), .an_speed(an_speed), .an_duplex(an_duplex),
        .sync_fail(sync_fail), .idle_timeout(idle_timeout), .phy_msg(phy_msg),
        .link_up(link_up), .speed(speed), .full_duplex(full_duplex),
        .link_stat(link_stat), .an_enable(an_enable), .an_restart(an_restart),
        .an_trigger(an_trigger), .an_idle_bypass(an_idle_bypass)
    );

    // Vector: control word, mode, engine inputs, expected link/speed/duplex.
    typedef struct packed {
        logic [31:0] ctrl;
        logic        sg;
        logic        lok;
        logic [1:0]  spd;
        logic        dup;
        logic        ito;
        logic        xl;
        logic [1:0]  xs;
        logic        xd;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VEC [NV] = '{
        '{32'h0001_0000, 1'b1, 1'b1, 2'b01, 1'b0, 1'b0, 1'b1, 2'b01, 1'b0}, // R3 R5 negotiated
        '{32'h0001_0000, 1'b1, 1'b0, 2'b00, 1'b1, 1'b1, 1'b0, 2'b00, 1'b1}, // R4 timeout off
        '{32'h0005_0000, 1'b0, 1'b0, 2'b00, 1'b0, 1'b1, 1'b1, 2'b00, 1'b0}, // R4 serdes timeout
        '{32'h0005_0000, 1'b1, 1'b0, 2'b10, 1'b1, 1'b1, 1'b0, 2'b10, 1'b1}, // R4 sgmii no timeout
        '{32'h0001_0021, 1'b1, 1'b0, 2'b01, 1'b0, 1'b0, 1'b1, 2'b01, 1'b0}, // R3 forced up
        '{32'h0001_0020, 1'b1, 1'b1, 2'b00, 1'b1, 1'b0, 1'b0, 2'b00, 1'b1}, // R3 forced down
        '{32'h0001_0012, 1'b1, 1'b1, 2'b10, 1'b1, 1'b0, 1'b1, 2'b01, 1'b0}, // R5 force speed/duplex
        '{32'h0000_0006, 1'b1, 1'b1, 2'b01, 1'b1, 1'b0, 1'b1, 2'b10, 1'b0}, // R6 AN off, code 11
        '{32'h0001_001E, 1'b1, 1'b1, 2'b00, 1'b0, 1'b0, 1'b1, 2'b10, 1'b1}, // R6 forced code 11
        '{32'h0000_0008, 1'b0, 1'b1, 2'b01, 1'b0, 1'b0, 1'b1, 2'b00, 1'b1}  // R5 serdes forced
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic do_wr(input logic [31:0] v);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1 reset readback", rd_data, 32'h0004_000C);
        check("R1 reset speed", {30'd0, speed}, 32'd2);
        check("R1 reset duplex", {31'd0, full_duplex}, 32'd1);

        // Table walk over resolution cases.
        for (int i = 0; i < NV; i++) begin
            do_wr(VEC[i].ctrl);
            sgmii_mode   = VEC[i].sg;
            an_link_ok   = VEC[i].lok;
            an_speed     = VEC[i].spd;
            an_duplex    = VEC[i].dup;
            idle_timeout = VEC[i].ito;
            #1;
            check($sformatf("R3/R4 link vec%0d", i), {31'd0, link_up}, {31'd0, VEC[i].xl});
            check($sformatf("R5/R6 speed vec%0d", i), {30'd0, speed}, {30'd0, VEC[i].xs});
            check($sformatf("R5 duplex vec%0d", i), {31'd0, full_duplex}, {31'd0, VEC[i].xd});
        end
        idle_timeout = 1'b0;

        // R2: reserved bits stay zero.
        do_wr(32'hFFFF_FFFF);
        check("R2 all-ones first cycle", rd_data, 32'h001F_007F);
        @(negedge clk);
        check("R2 all-ones later", rd_data, 32'h001D_007F);

        // R8: restart pulse for one cycle.
        do_wr(32'h0003_0000);
        check("R8 restart pulse", {31'd0, an_restart}, 32'd1);
        check("R8 restart readback", rd_data, 32'h0003_0000);
        @(negedge clk);
        check("R8 restart cleared", {31'd0, an_restart}, 32'd0);
        check("R8 readback cleared", rd_data, 32'h0001_0000);

        // R7: latch-low status.
        sgmii_mode = 1'b1;
        an_link_ok = 1'b1;
        do_wr(32'h0000_0040);
        @(negedge clk);
        check("R7 status live up", {31'd0, link_stat}, 32'd1);
        an_link_ok = 1'b0;
        #1;
        check("R7 status follows drop", {31'd0, link_stat}, 32'd0);
        @(negedge clk);
        an_link_ok = 1'b1;
        #1;
        check("R7 held low after recovery", {31'd0, link_stat}, 32'd0);
        @(negedge clk);
        check("R7 still held", {31'd0, link_stat}, 32'd0);
        stat_rd = 1'b1;
        @(negedge clk);
        stat_rd = 1'b0;
        #1;
        check("R7 released by read", {31'd0, link_stat}, 32'd1);
        // Read while the link is still low releases the hold.
        @(negedge clk);
        an_link_ok = 1'b0;
        @(negedge clk);
        stat_rd = 1'b1;
        @(negedge clk);
        stat_rd = 1'b0;
        #1;
        check("R7 low after read while down", {31'd0, link_stat}, 32'd0);
        an_link_ok = 1'b1;
        #1;
        check("R7 live after read while down", {31'd0, link_stat}, 32'd1);
        // Latch disabled: status is live.
        do_wr(32'h0000_0000);
        an_link_ok = 1'b0;
        @(negedge clk);
        an_link_ok = 1'b1;
        #1;
        check("R7 no latch when disabled", {31'd0, link_stat}, 32'd1);

        // R9: trigger sources and SGMII gating.
        sgmii_mode = 1'b1;
        sync_fail = 1'b1;
        do_wr(32'h0001_0000);
        check("R9 enable write triggers", {31'd0, an_trigger}, 32'd1);
        @(negedge clk);
        check("R9 sgmii sync fail gated", {31'd0, an_trigger}, 32'd0);
        do_wr(32'h0011_0000);
        @(negedge clk);
        check("R9 sgmii sync fail with trigger enable", {31'd0, an_trigger}, 32'd1);
        do_wr(32'h0001_0000);
        @(negedge clk);
        sgmii_mode = 1'b0;
        #1;
        check("R9 serdes sync fail", {31'd0, an_trigger}, 32'd1);
        sgmii_mode = 1'b1;
        phy_msg = 1'b1;
        #1;
        check("R9 phy message", {31'd0, an_trigger}, 32'd1);
        do_wr(32'h0000_0000);
        check("R9 disabled no trigger", {31'd0, an_trigger}, 32'd0);
        phy_msg = 1'b0;
        sync_fail = 1'b0;

        // R10: idle-detect bypass.
        do_wr(32'h0009_0000);
        check("R10 bypass sgmii", {31'd0, an_idle_bypass}, 32'd1);
        sgmii_mode = 1'b0;
        #1;
        check("R10 bypass serdes", {31'd0, an_idle_bypass}, 32'd0);
        sgmii_mode = 1'b1;
        do_wr(32'h0008_0000);
        check("R10 bypass AN off", {31'd0, an_idle_bypass}, 32'd0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule